// File: doc/BRIEF.md
# Capability System Register Swap Unit

This block handles the swap-style access to the four special capability registers that steer trap delivery. An instruction names one register by a 5-bit index and supplies a source register index and a source capability. The block returns the register's old contents on the same cycle. It stores a new value at the next clock edge, but only when the source register index is nonzero. The pipeline drives one request per cycle and takes the read value back combinationally.

Two registers feed control flow: the trap vector and the saved exception PC. Writes to these two are checked and legalized on the way in. Their low address bits are forced to zero. Any misalignment, sealing or missing execute permission clears the tag instead of raising a fault. Because values are cleaned when they are stored, nothing needs to be corrected when the register is later read or used for a jump. The other two registers keep whatever is written to them.

An access needs the access-system-registers permission in the current program-counter capability. Separately, a use of the old integer trap-vector or exception-PC CSR addresses is flagged as a reserved instruction.

Top module: `scr_file`

## Requirements
- R1: When `req_i` is high and `pcc_asr_perm_i` is low, `access_fault_o` is 1, `illegal_o` is 0, `rdata_o` is all zeros, and no register changes. This check takes priority over index decoding.
- R2: Index 28 selects the trap vector, 29 the trap data register, 30 the scratch register and 31 the exception PC. A permitted request with any other index raises `illegal_o`, returns zero and changes no register.
- R3: A permitted request with a valid index returns that register's value from before the request on `rdata_o` in the same cycle. A write is visible from the following cycle.
- R4: When `src_idx_i` is 0, no register is written. The old value is still returned.
- R5: A write to the trap vector stores address bits [1:0] as zero, and clears the tag if either bit was set.
- R6: A write to the trap vector clears the tag if the value is sealed (object type field nonzero) or lacks execute permission.
- R7: A write to the exception PC stores address bit 0 as zero, and clears the tag if that bit was set.
- R8: A write to the exception PC clears the tag if the value is sealed or lacks execute permission.
- R9: Writes to the trap data and scratch registers store the value unchanged, including its tag.
- R10: `csr_reserved_o` is 1 exactly when `csr_valid_i` is high and `csr_addr_i` is 0x305 or 0x341.
- R11: After reset, the trap vector and exception PC hold the executable root and the trap data register holds the memory root. The scratch register holds all zeros.
- R12: Capability layout, with default widths: tag bit 63, object type [62:60], permissions [59:54] (execute is permission bit 1), bounds [53:32], address [31:0]. The executable root has tag 1, object type 0, permissions 6'b100011, bounds all ones and address 0. The memory root is the same except for permissions 6'b011101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Swap request valid |
| scr_idx_i | input | 5 | Special register index |
| src_idx_i | input | 5 | Source register index; 0 means read only |
| wdata_i | input | 64 | Source capability to store |
| pcc_asr_perm_i | input | 1 | Access-system-registers permission of the current PC capability |
| csr_valid_i | input | 1 | Integer CSR instruction valid |
| csr_addr_i | input | 12 | Integer CSR address |
| rdata_o | output | 64 | Old register value |
| access_fault_o | output | 1 | Permission violation |
| illegal_o | output | 1 | Nonexistent register index |
| csr_reserved_o | output | 1 | Legacy CSR access is reserved |

## Verification
The bench targets several error-prone cases:
- A trap vector with only bit 0 or only bit 1 of its address set. A design that tested just one of the two bits would leave the tag on.
- A sealed value that is otherwise executable and aligned. A design that ignored sealing would keep the tag.
- An exception PC with address bit 1 set. A design that copied the trap-vector rule would wrongly clear that bit.
- Reads with source index zero, and requests without permission. A design that wrote on these would corrupt the register, and the following read-back would show it.
- Misaligned values written to the trap data register. A design that applied legalization to every slot would alter them.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned NUM_SCR = 4;
  localparam int unsigned SLOT_W  = $clog2(NUM_SCR);

  typedef enum logic [SLOT_W-1:0] {
    SLOT_TVEC    = 2'd0,
    SLOT_TDATA   = 2'd1,
    SLOT_SCRATCH = 2'd2,
    SLOT_EPC     = 2'd3
  } scr_slot_e;

  // address bits forced to zero on write; zero means stored verbatim
  function automatic int unsigned slot_low_bits(int unsigned slot);
    case (slot)
      SLOT_TVEC: return 2;
      SLOT_EPC:  return 1;
      default:   return 0;
    endcase
  endfunction

  function automatic bit slot_checked(int unsigned slot);
    return (slot == SLOT_TVEC) || (slot == SLOT_EPC);
  endfunction

  function automatic bit slot_exec_root(int unsigned slot);
    return (slot == SLOT_TVEC) || (slot == SLOT_EPC);
  endfunction
endpackage

// File: rtl/scr_access_ctrl.sv
module scr_access_ctrl #(
  parameter int unsigned SCR_IDX_W = 5,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned SCR_BASE  = 28,
  localparam int unsigned SLOT_W   = scr_pkg::SLOT_W
) (
  input  logic                 req_i,
  input  logic [SCR_IDX_W-1:0] scr_idx_i,
  input  logic [REG_IDX_W-1:0] src_idx_i,
  input  logic                 asr_perm_i,
  output logic                 fault_o,
  output logic                 illegal_o,
  output logic                 rd_en_o,
  output logic                 wr_en_o,
  output logic [SLOT_W-1:0]    slot_o
);
  localparam logic [SCR_IDX_W-1:0] BASE = SCR_IDX_W'(SCR_BASE);

  logic in_range;

  assign in_range  = (scr_idx_i >> SLOT_W) == (BASE >> SLOT_W);
  assign slot_o    = scr_idx_i[SLOT_W-1:0];
  assign fault_o   = req_i && !asr_perm_i;
  assign illegal_o = req_i && asr_perm_i && !in_range;
  assign rd_en_o   = req_i && asr_perm_i && in_range;
  assign wr_en_o   = rd_en_o && (src_idx_i != '0);
endmodule

// File: rtl/scr_legalizer.sv
module scr_legalizer #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BND_W    = 22,
  parameter int unsigned PERM_W   = 6,
  parameter int unsigned OTYPE_W  = 3,
  parameter int unsigned EXEC_BIT = 1,
  parameter int unsigned LOW_BITS = 0,
  parameter bit          CHECKED  = 1'b0,
  localparam int unsigned CAP_W   = 1 + OTYPE_W + PERM_W + BND_W + ADDR_W,
  localparam int unsigned PERM_LSB  = ADDR_W + BND_W,
  localparam int unsigned OTYPE_LSB = PERM_LSB + PERM_W
) (
  input  logic [CAP_W-1:0] cap_i,
  output logic [CAP_W-1:0] cap_o
);
  if (!CHECKED) begin : g_plain
    assign cap_o = cap_i;
  end else begin : g_checked
    logic sealed, no_exec, misaligned, bad;
    assign sealed  = cap_i[OTYPE_LSB +: OTYPE_W] != '0;
    assign no_exec = !cap_i[PERM_LSB + EXEC_BIT];
    if (LOW_BITS == 0) begin : g_nolow
      assign misaligned = 1'b0;
      assign cap_o = {cap_i[CAP_W-1] & ~bad, cap_i[CAP_W-2:0]};
    end else begin : g_low
      assign misaligned = cap_i[LOW_BITS-1:0] != '0;
      assign cap_o = {cap_i[CAP_W-1] & ~bad, cap_i[CAP_W-2:LOW_BITS], LOW_BITS'(0)};
    end
    assign bad = misaligned | sealed | no_exec;
  end
endmodule

// File: rtl/scr_legacy_csr_trap.sv
module scr_legacy_csr_trap #(
  parameter int unsigned  CSR_ADDR_W = 12,
  parameter logic [11:0]  TVEC_CSR   = 12'h305,
  parameter logic [11:0]  EPC_CSR    = 12'h341
) (
  input  logic                  csr_valid_i,
  input  logic [CSR_ADDR_W-1:0] csr_addr_i,
  output logic                  reserved_o
);
  logic hit;
  assign hit = (csr_addr_i == CSR_ADDR_W'(TVEC_CSR)) || (csr_addr_i == CSR_ADDR_W'(EPC_CSR));
  assign reserved_o = csr_valid_i && hit;
endmodule

// File: rtl/scr_file.sv
module scr_file #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BND_W      = 22,
  parameter int unsigned PERM_W     = 6,
  parameter int unsigned OTYPE_W    = 3,
  parameter int unsigned EXEC_BIT   = 1,
  parameter logic [5:0]  EXEC_PERMS = 6'b100011,
  parameter logic [5:0]  MEM_PERMS  = 6'b011101,
  parameter int unsigned SCR_IDX_W  = 5,
  parameter int unsigned REG_IDX_W  = 5,
  parameter int unsigned SCR_BASE   = 28,
  parameter int unsigned CSR_ADDR_W = 12,
  localparam int unsigned CAP_W     = 1 + OTYPE_W + PERM_W + BND_W + ADDR_W,
  localparam int unsigned NUM_SCR   = scr_pkg::NUM_SCR,
  localparam int unsigned SLOT_W    = scr_pkg::SLOT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [SCR_IDX_W-1:0]  scr_idx_i,
  input  logic [REG_IDX_W-1:0]  src_idx_i,
  input  logic [CAP_W-1:0]      wdata_i,
  input  logic                  pcc_asr_perm_i,
  input  logic                  csr_valid_i,
  input  logic [CSR_ADDR_W-1:0] csr_addr_i,
  output logic [CAP_W-1:0]      rdata_o,
  output logic                  access_fault_o,
  output logic                  illegal_o,
  output logic                  csr_reserved_o
);
  localparam logic [CAP_W-1:0] EXEC_ROOT =
    {1'b1, OTYPE_W'(0), PERM_W'(EXEC_PERMS), {BND_W{1'b1}}, ADDR_W'(0)};
  localparam logic [CAP_W-1:0] MEM_ROOT =
    {1'b1, OTYPE_W'(0), PERM_W'(MEM_PERMS), {BND_W{1'b1}}, ADDR_W'(0)};

  logic                           rd_en, wr_en;
  logic [SLOT_W-1:0]              slot;
  logic [NUM_SCR-1:0][CAP_W-1:0]  scr_q;
  logic [NUM_SCR-1:0][CAP_W-1:0]  legal_d;

  scr_access_ctrl #(
    .SCR_IDX_W (SCR_IDX_W),
    .REG_IDX_W (REG_IDX_W),
    .SCR_BASE  (SCR_BASE)
  ) u_ctrl (
    .req_i      (req_i),
    .scr_idx_i  (scr_idx_i),
    .src_idx_i  (src_idx_i),
    .asr_perm_i (pcc_asr_perm_i),
    .fault_o    (access_fault_o),
    .illegal_o  (illegal_o),
    .rd_en_o    (rd_en),
    .wr_en_o    (wr_en),
    .slot_o     (slot)
  );

  scr_legacy_csr_trap #(
    .CSR_ADDR_W (CSR_ADDR_W)
  ) u_legacy (
    .csr_valid_i (csr_valid_i),
    .csr_addr_i  (csr_addr_i),
    .reserved_o  (csr_reserved_o)
  );

  for (genvar s = 0; s < NUM_SCR; s++) begin : g_slot
    localparam logic [CAP_W-1:0] RST_VAL =
      scr_pkg::slot_exec_root(s) ? EXEC_ROOT :
      (s == scr_pkg::SLOT_TDATA) ? MEM_ROOT : '0;

    scr_legalizer #(
      .ADDR_W   (ADDR_W),
      .BND_W    (BND_W),
      .PERM_W   (PERM_W),
      .OTYPE_W  (OTYPE_W),
      .EXEC_BIT (EXEC_BIT),
      .LOW_BITS (scr_pkg::slot_low_bits(s)),
      .CHECKED  (scr_pkg::slot_checked(s))
    ) u_legal (
      .cap_i (wdata_i),
      .cap_o (legal_d[s])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scr_q[s] <= RST_VAL;
      end else if (wr_en && (slot == SLOT_W'(s))) begin
        scr_q[s] <= legal_d[s];
      end
    end
  end

  assign rdata_o = rd_en ? scr_q[slot] : '0;
endmodule

// File: rtl/scr_file_chk.sv
module scr_file_chk #(
  parameter int unsigned CAP_W     = 64,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BND_W     = 22,
  parameter int unsigned PERM_W    = 6,
  parameter int unsigned OTYPE_W   = 3,
  parameter int unsigned EXEC_BIT  = 1,
  parameter int unsigned SCR_IDX_W = 5,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned SCR_BASE  = 28
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic [SCR_IDX_W-1:0] scr_idx_i,
  input logic [REG_IDX_W-1:0] src_idx_i,
  input logic [CAP_W-1:0]     wdata_i,
  input logic                 access_fault_o,
  input logic                 illegal_o,
  input logic [3:0][CAP_W-1:0] scr_q
);
  localparam int unsigned PERM_LSB  = ADDR_W + BND_W;
  localparam int unsigned OTYPE_LSB = PERM_LSB + PERM_W;

  logic ok_wr;
  assign ok_wr = req_i && !access_fault_o && !illegal_o && (src_idx_i != '0);

  AST_FAULT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && access_fault_o |=> $stable(scr_q)); // R1
  AST_BAD_INDEX_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !access_fault_o && (scr_idx_i < SCR_IDX_W'(SCR_BASE)) |-> illegal_o); // R2
  AST_SRC_ZERO_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (src_idx_i == '0) |=> $stable(scr_q)); // R4
  AST_TVEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scr_q[0][1:0] == 2'b00); // R5
  AST_TVEC_TAG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scr_q[0][CAP_W-1] |-> scr_q[0][PERM_LSB+EXEC_BIT] && (scr_q[0][OTYPE_LSB +: OTYPE_W] == '0)); // R6
  AST_EPC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scr_q[3][0] == 1'b0); // R7
  AST_EPC_TAG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scr_q[3][CAP_W-1] |-> scr_q[3][PERM_LSB+EXEC_BIT] && (scr_q[3][OTYPE_LSB +: OTYPE_W] == '0)); // R8
  AST_TDATA_VERBATIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_wr && (scr_idx_i == SCR_IDX_W'(SCR_BASE + 1)) |=> scr_q[1] == $past(wdata_i)); // R9
  AST_SCRATCH_VERBATIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_wr && (scr_idx_i == SCR_IDX_W'(SCR_BASE + 2)) |=> scr_q[2] == $past(wdata_i)); // R9
endmodule

bind scr_file scr_file_chk #(
  .CAP_W     (CAP_W),
  .ADDR_W    (ADDR_W),
  .BND_W     (BND_W),
  .PERM_W    (PERM_W),
  .OTYPE_W   (OTYPE_W),
  .EXEC_BIT  (EXEC_BIT),
  .SCR_IDX_W (SCR_IDX_W),
  .REG_IDX_W (REG_IDX_W),
  .SCR_BASE  (SCR_BASE)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .scr_idx_i      (scr_idx_i),
  .src_idx_i      (src_idx_i),
  .wdata_i        (wdata_i),
  .access_fault_o (access_fault_o),
  .illegal_o      (illegal_o),
  .scr_q          (scr_q)
);

// File: tb/tb_scr_file.sv
module tb_scr_file;
  localparam logic [63:0] EXEC_ROOT = {1'b1, 3'b0, 6'b100011, 22'h3fffff, 32'h0};
  localparam logic [63:0] MEM_ROOT  = {1'b1, 3'b0, 6'b011101, 22'h3fffff, 32'h0};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic [4:0]  scr_idx = '0;
  logic [4:0]  src_idx = '0;
  logic [63:0] wdata = '0;
  logic        asr = 1'b0;
  logic        csr_valid = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] rdata;
  logic        fault, illegal, reserved;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] model [4];

  always #4 clk = ~clk;

  scr_file dut (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req), .scr_idx_i (scr_idx),
    .src_idx_i (src_idx), .wdata_i (wdata), .pcc_asr_perm_i (asr),
    .csr_valid_i (csr_valid), .csr_addr_i (csr_addr), .rdata_o (rdata),
    .access_fault_o (fault), .illegal_o (illegal), .csr_reserved_o (reserved)
  );

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_store(input int slot, input logic [63:0] v);
    logic [63:0] r = v;
    logic bad;
    if (slot == 0) begin
      bad = (v[1:0] != 0) || (v[62:60] != 0) || !v[55];
      r[1:0] = 2'b00;
      r[63] = v[63] & ~bad;
    end else if (slot == 3) begin
      bad = v[0] || (v[62:60] != 0) || !v[55];
      r[0] = 1'b0;
      r[63] = v[63] & ~bad;
    end
    return r;
  endfunction

  task automatic access(input logic [4:0] idx, input logic [4:0] src,
                        input logic [63:0] wd, input logic perm, input string tag);
    logic exp_f, exp_i;
    logic [63:0] exp_rd;
    exp_f = !perm;
    exp_i = perm && (idx < 5'd28);
    exp_rd = (!exp_f && !exp_i) ? model[idx - 5'd28] : '0;
    @(negedge clk);
    req = 1'b1; scr_idx = idx; src_idx = src; wdata = wd; asr = perm;
    #1;
    check({tag, " R1 fault"}, {63'b0, fault}, {63'b0, exp_f});
    check({tag, " R2 illegal"}, {63'b0, illegal}, {63'b0, exp_i});
    check({tag, " R3 rdata"}, rdata, exp_rd);
    if (!exp_f && !exp_i && src != 0) model[idx - 5'd28] = exp_store(int'(idx - 5'd28), wd);
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic read_back(input int slot, input string tag);
    access(5'(28 + slot), 5'd0, 64'hdead_beef_dead_beef, 1'b1, tag);
  endtask

  task automatic csr_probe(input logic v, input logic [11:0] a, input logic exp);
    @(negedge clk);
    csr_valid = v; csr_addr = a;
    #1 check("R10 legacy csr", {63'b0, reserved}, {63'b0, exp});
    csr_valid = 1'b0;
  endtask

  function automatic logic [63:0] rand_cap();
    logic [63:0] v = {$urandom, $urandom};
    if ($urandom_range(0, 1) == 1) begin
      v[63] = 1'b1; v[62:60] = 3'b0; v[55] = 1'b1;
      if ($urandom_range(0, 1) == 1) v[1:0] = 2'b00;
    end
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model[0] = EXEC_ROOT; model[1] = MEM_ROOT; model[2] = '0; model[3] = EXEC_ROOT;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R11 reset values
    for (int s = 0; s < 4; s++) read_back(s, "R11 reset");

    // R1 no permission: no write, zero data
    access(5'd30, 5'd7, 64'h1234, 1'b0, "R1 noperm");
    read_back(2, "R1 scratch unchanged");
    // R2 nonexistent index
    access(5'd27, 5'd3, 64'h55, 1'b1, "R2 idx27");
    access(5'd0, 5'd3, 64'h55, 1'b1, "R2 idx0");
    // R4 source zero
    access(5'd29, 5'd0, 64'hffff, 1'b1, "R4 src0");
    read_back(1, "R4 tdata unchanged");
    // R5 tvec low bits, each one alone
    access(5'd28, 5'd1, {EXEC_ROOT[63:32], 32'h1000_0001}, 1'b1, "R5 tvec bit0");
    read_back(0, "R5 tvec bit0 readback");
    access(5'd28, 5'd1, {EXEC_ROOT[63:32], 32'h1000_0002}, 1'b1, "R5 tvec bit1");
    read_back(0, "R5 tvec bit1 readback");
    access(5'd28, 5'd1, {EXEC_ROOT[63:32], 32'h1000_0100}, 1'b1, "R5 tvec ok");
    read_back(0, "R5 tvec aligned readback");
    // R6 sealed / non-exec
    access(5'd28, 5'd2, {1'b1, 3'b010, EXEC_ROOT[59:32], 32'h200}, 1'b1, "R6 tvec sealed");
    read_back(0, "R6 tvec sealed readback");
    access(5'd28, 5'd2, {MEM_ROOT[63:32], 32'h200}, 1'b1, "R6 tvec noexec");
    read_back(0, "R6 tvec noexec readback");
    // R7 epc bit0 and bit1
    access(5'd31, 5'd4, {EXEC_ROOT[63:32], 32'h0000_0043}, 1'b1, "R7 epc bit0");
    read_back(3, "R7 epc bit0 readback");
    access(5'd31, 5'd4, {EXEC_ROOT[63:32], 32'h0000_0042}, 1'b1, "R7 epc bit1 kept");
    read_back(3, "R7 epc bit1 readback");
    // R8
    access(5'd31, 5'd4, {1'b1, 3'b001, EXEC_ROOT[59:32], 32'h80}, 1'b1, "R8 epc sealed");
    read_back(3, "R8 epc sealed readback");
    access(5'd31, 5'd4, {MEM_ROOT[63:32], 32'h80}, 1'b1, "R8 epc noexec");
    read_back(3, "R8 epc noexec readback");
    // R9 verbatim
    access(5'd29, 5'd9, {1'b1, 3'b111, MEM_ROOT[59:32], 32'h3}, 1'b1, "R9 tdata");
    read_back(1, "R9 tdata readback");
    access(5'd30, 5'd9, 64'h8000_0000_0000_0003, 1'b1, "R9 scratch");
    read_back(2, "R9 scratch readback");
    // R10
    csr_probe(1'b1, 12'h305, 1'b1);
    csr_probe(1'b1, 12'h341, 1'b1);
    csr_probe(1'b1, 12'h300, 1'b0);
    csr_probe(1'b0, 12'h305, 1'b0);
    // R12 random mixed traffic against layout model
    for (int i = 0; i < 400; i++) begin
      logic [4:0] idx, src;
      idx = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'(28 + $urandom_range(0, 3));
      src = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
      access(idx, src, rand_cap(), ($urandom_range(0, 9) != 0), "R12 random");
    end
    for (int s = 0; s < 4; s++) read_back(s, "R3 final readback");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule